// File: doc/BRIEF.md
# Return-Address Stack Predictor

This block predicts the targets of subroutine returns for a fetch-stage branch predictor. When the front end predicts a call, it presents the fall-through address and the block pushes it onto a small circular stack. When the front end predicts a return, the block supplies the most recently pushed address as the predicted target in the same cycle, together with a flag that says whether the stack held a live entry.

Every predicted branch can save a snapshot of the stack position (the top index and the occupancy) in a small table, keyed by a branch tag. When that branch later turns out to be mispredicted, the front end presents the tag on the recovery port. The block then restores the saved position in a single cycle. Only the position is repaired. Slots that wrong-path calls overwrote keep their wrong-path contents, so some corruption remains after recovery.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty and every slot holds zero. A return predicted straight after reset gives `pred_valid_o` = 0 and `pred_target_o` = 0.
- R2: A call writes `call_addr_i` to the slot at the top index and advances the index by one. During a return cycle, `pred_target_o` combinationally shows the newest live entry, so returns yield the addresses in last-in, first-out order.
- R3: The stack holds DEPTH entries, and the index wraps modulo DEPTH. A call on a full stack overwrites the oldest entry and raises no stall. The occupancy saturates at DEPTH.
- R4: A return on an empty stack drives `pred_valid_o` = 0 and still shows the slot just below the top index on `pred_target_o`. It leaves the index and the occupancy unchanged.
- R5: A call and a return in the same cycle predict the current top with `pred_valid_o` = 1, unless the stack is empty. The new address then replaces the top slot, and the index stays where it was.
- R6: When `ckpt_i` is high, the block stores the stack position that holds after the cycle's own call or return under `ckpt_tag_i`. The stored entry survives later cycles until the same tag is written again. Table entries reset to the empty position (index 0, occupancy 0).
- R7: When `flush_i` is high, the position stored under `flush_tag_i` becomes the live position at the next clock edge.
- R8: Recovery has priority. In a cycle with `flush_i` high, the block drops any call, return or checkpoint, and `pred_valid_o` is 0.
- R9: Recovery restores only the position, not the slot contents. A slot that a wrong-path call overwrote keeps the wrong-path address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | A call is predicted this cycle |
| call_addr_i | input | ADDR_W | Fall-through address to push |
| ret_i | input | 1 | A return is predicted this cycle |
| ckpt_i | input | 1 | Save the stack position for a predicted branch |
| ckpt_tag_i | input | TAG_W | Tag under which the position is saved |
| flush_i | input | 1 | Misprediction recovery request |
| flush_tag_i | input | TAG_W | Tag of the position to restore |
| pred_target_o | output | ADDR_W | Predicted return target (newest entry) |
| pred_valid_o | output | 1 | Return predicted from a live entry |

## Verification
The prediction outputs are combinational from the registered stack state. The bench therefore checks them in the same cycle as the return request: it drives the inputs just after a falling edge and samples one time unit later. A call, a checkpoint or a recovery becomes visible only after the following rising edge. Each such effect is checked through a return driven in a later cycle, counting exactly one register stage between the stimulus and the observed target. The overflow, empty-return and recovery corner cases use directed sequences, and the bench computes their expected slot contents by hand from the wrap-around rule.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Operation applied to the stack in one cycle
    typedef enum logic [1:0] {
        RAS_IDLE = 2'd0,
        RAS_PUSH = 2'd1,
        RAS_POP  = 2'd2,
        RAS_SWAP = 2'd3
    } ras_op_e;

    function automatic ras_op_e ras_decode(input logic call, input logic ret, input logic flush);
        ras_op_e op;
        if (flush)            op = RAS_IDLE;
        else if (call && ret) op = RAS_SWAP;
        else if (call)        op = RAS_PUSH;
        else if (ret)         op = RAS_POP;
        else                  op = RAS_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ras_op_e          op_i,
    input  logic             flush_i,
    input  logic [PTR_W-1:0] rest_ptr_i,
    input  logic [CNT_W-1:0] rest_cnt_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [PTR_W-1:0] spec_ptr_o,
    output logic [CNT_W-1:0] spec_cnt_o,
    output logic [PTR_W-1:0] top_idx_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } pos_t;

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    pos_t pos_q, pos_d, spec;
    logic [PTR_W-1:0] up_idx, down_idx;

    always_comb begin
        up_idx   = (pos_q.ptr == LAST_IDX) ? '0 : pos_q.ptr + 1'b1;
        down_idx = (pos_q.ptr == '0) ? LAST_IDX : pos_q.ptr - 1'b1;

        spec     = pos_q;
        wr_en_o  = 1'b0;
        wr_idx_o = pos_q.ptr;

        unique case (op_i)
            RAS_PUSH: begin
                wr_en_o  = 1'b1;
                wr_idx_o = pos_q.ptr;
                spec.ptr = up_idx;
                spec.cnt = (pos_q.cnt == FULL_CNT) ? pos_q.cnt : pos_q.cnt + 1'b1;
            end
            RAS_POP: begin
                if (pos_q.cnt != '0) begin
                    spec.ptr = down_idx;
                    spec.cnt = pos_q.cnt - 1'b1;
                end
            end
            RAS_SWAP: begin
                wr_en_o  = 1'b1;
                wr_idx_o = down_idx;
                if (pos_q.cnt == '0) spec.cnt = CNT_W'(1);
            end
            default: ;
        endcase

        if (flush_i) begin
            wr_en_o   = 1'b0;
            pos_d.ptr = rest_ptr_i;
            pos_d.cnt = rest_cnt_i;
        end else begin
            pos_d = spec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign ptr_o      = pos_q.ptr;
    assign cnt_o      = pos_q.cnt;
    assign spec_ptr_o = spec.ptr;
    assign spec_cnt_o = spec.cnt;
    assign top_idx_o  = down_idx;

endmodule

// File: rtl/ras_entry_store.sv
module ras_entry_store #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o
);

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [ADDR_W-1:0] slot_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = (wr_en_i && (wr_idx_i == PTR_W'(i))) ? wr_data_i : slot_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/ras_ckpt_table.sv
module ras_ckpt_table #(
    parameter int TAG_W = 3,
    parameter int PTR_W = 2,
    parameter int CNT_W = 3,
    localparam int ENTRIES = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [CNT_W-1:0] wr_cnt_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [CNT_W-1:0] rd_cnt_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } snap_t;

    snap_t snap_q [ENTRIES];
    snap_t snap_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            snap_d[i] = snap_q[i];
            if (wr_en_i && (wr_tag_i == TAG_W'(i))) begin
                snap_d[i].ptr = wr_ptr_i;
                snap_d[i].cnt = wr_cnt_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) snap_q[i] <= '0;
            else        snap_q[i] <= snap_d[i];
        end
    end

    assign rd_ptr_o = snap_q[rd_tag_i].ptr;
    assign rd_cnt_o = snap_q[rd_tag_i].cnt;

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic [ADDR_W-1:0] call_addr_i,
    input  logic              ret_i,
    input  logic              ckpt_i,
    input  logic [TAG_W-1:0]  ckpt_tag_i,
    input  logic              flush_i,
    input  logic [TAG_W-1:0]  flush_tag_i,
    output logic [ADDR_W-1:0] pred_target_o,
    output logic              pred_valid_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    ras_op_e          op;
    logic [PTR_W-1:0] top_ptr, spec_ptr, rest_ptr, top_idx, wr_idx;
    logic [CNT_W-1:0] top_cnt, spec_cnt, rest_cnt;
    logic             wr_en, ckpt_we;
    logic [ADDR_W-1:0] stack_top;

    always_comb begin
        op      = ras_decode(call_i, ret_i, flush_i);
        ckpt_we = ckpt_i && !flush_i;
    end

    ras_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .flush_i    (flush_i),
        .rest_ptr_i (rest_ptr),
        .rest_cnt_i (rest_cnt),
        .ptr_o      (top_ptr),
        .cnt_o      (top_cnt),
        .spec_ptr_o (spec_ptr),
        .spec_cnt_o (spec_cnt),
        .top_idx_o  (top_idx),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx)
    );

    ras_entry_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (call_addr_i),
        .rd_idx_i  (top_idx),
        .rd_data_o (stack_top)
    );

    ras_ckpt_table #(.TAG_W(TAG_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) ckpt_tbl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (ckpt_we),
        .wr_tag_i (ckpt_tag_i),
        .wr_ptr_i (spec_ptr),
        .wr_cnt_i (spec_cnt),
        .rd_tag_i (flush_tag_i),
        .rd_ptr_o (rest_ptr),
        .rd_cnt_o (rest_cnt)
    );

    assign pred_target_o = stack_top;
    assign pred_valid_o  = ret_i && !flush_i && (top_cnt != '0);

endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_i,
    input logic [ADDR_W-1:0] call_addr_i,
    input logic              ret_i,
    input logic              flush_i,
    input logic              pred_valid_o,
    input logic [PTR_W-1:0]  top_ptr,
    input logic [CNT_W-1:0]  top_cnt,
    input logic [PTR_W-1:0]  rest_ptr,
    input logic [CNT_W-1:0]  rest_cnt,
    input logic              ckpt_we,
    input logic [ADDR_W-1:0] stack_top
);

    assert_valid_only_on_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> (ret_i && !flush_i));

    assert_push_becomes_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !flush_i) |=> (stack_top == $past(call_addr_i)));

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(top_cnt) <= DEPTH);

    assert_push_count_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !flush_i) |=>
            (int'(top_cnt) == ((int'($past(top_cnt)) == DEPTH) ? DEPTH : int'($past(top_cnt)) + 1)));

    assert_swap_keeps_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i && !flush_i) |=> ($stable(top_ptr) && stack_top == $past(call_addr_i)));

    assert_flush_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (top_ptr == $past(rest_ptr) && top_cnt == $past(rest_cnt)));

    assert_flush_drops_ckpt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !ckpt_we);

endmodule

bind ras_predictor ras_predictor_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_i       (call_i),
    .call_addr_i  (call_addr_i),
    .ret_i        (ret_i),
    .flush_i      (flush_i),
    .pred_valid_o (pred_valid_o),
    .top_ptr      (top_ptr),
    .top_cnt      (top_cnt),
    .rest_ptr     (rest_ptr),
    .rest_cnt     (rest_cnt),
    .ckpt_we      (ckpt_we),
    .stack_top    (stack_top)
);

// File: tb/ras_predictor_tb_top.sv
module ras_predictor_tb_top;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              call_i = 1'b0;
    logic [ADDR_W-1:0] call_addr_i = '0;
    logic              ret_i = 1'b0;
    logic              ckpt_i = 1'b0;
    logic [TAG_W-1:0]  ckpt_tag_i = '0;
    logic              flush_i = 1'b0;
    logic [TAG_W-1:0]  flush_tag_i = '0;
    logic [ADDR_W-1:0] pred_target_o;
    logic              pred_valid_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    ras_predictor #(.DEPTH(4), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .call_i        (call_i),
        .call_addr_i   (call_addr_i),
        .ret_i         (ret_i),
        .ckpt_i        (ckpt_i),
        .ckpt_tag_i    (ckpt_tag_i),
        .flush_i       (flush_i),
        .flush_tag_i   (flush_tag_i),
        .pred_target_o (pred_target_o),
        .pred_valid_o  (pred_valid_o)
    );

    typedef struct packed {
        logic        call;
        logic        ret;
        logic [31:0] addr;
        logic        exp_v;
        logic [31:0] exp_t;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 32'h0,   1'b0, 32'h0},   // R1 return after reset
        '{1'b1, 1'b0, 32'h100, 1'b0, 32'h0},   // R2 push A
        '{1'b1, 1'b0, 32'h200, 1'b0, 32'h100}, // R2 push B
        '{1'b0, 1'b1, 32'h0,   1'b1, 32'h200}, // R2 pop B
        '{1'b0, 1'b1, 32'h0,   1'b1, 32'h100}, // R2 pop A
        '{1'b0, 1'b1, 32'h0,   1'b0, 32'h0},   // R4 empty pop
        '{1'b1, 1'b0, 32'h300, 1'b0, 32'h0},   // R4 push after empty pop
        '{1'b1, 1'b1, 32'h400, 1'b1, 32'h300}, // R5 call and return together
        '{1'b0, 1'b1, 32'h0,   1'b1, 32'h400}, // R5 replaced top
        '{1'b0, 1'b1, 32'h0,   1'b0, 32'h0}    // R5 index unchanged, now empty
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic call, input logic ret, input logic [31:0] addr,
                         input logic ck, input logic [TAG_W-1:0] ctag,
                         input logic fl, input logic [TAG_W-1:0] ftag);
        @(negedge clk);
        call_i      = call;
        ret_i       = ret;
        call_addr_i = addr;
        ckpt_i      = ck;
        ckpt_tag_i  = ctag;
        flush_i     = fl;
        flush_tag_i = ftag;
        #1;
    endtask

    task automatic pop_check(input string req, input logic v, input logic [31:0] t);
        drive(1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0);
        check(req, {31'b0, pred_valid_o}, {31'b0, v});
        check(req, pred_target_o, t);
    endtask

    task automatic push(input logic [31:0] a);
        drive(1'b1, 1'b0, a, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        call_i = 1'b0; ret_i = 1'b0; ckpt_i = 1'b0; flush_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 valid low in reset", {31'b0, pred_valid_o}, 32'h0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].call, VECS[i].ret, VECS[i].addr, 1'b0, '0, 1'b0, '0);
            check($sformatf("R2/R4/R5 vector %0d valid", i), {31'b0, pred_valid_o}, {31'b0, VECS[i].exp_v});
            check($sformatf("R2/R4/R5 vector %0d target", i), pred_target_o, VECS[i].exp_t);
        end

        // R3 overflow: five pushes into four slots
        for (int i = 0; i < 5; i++) push(32'hE0 + 32'(i));
        pop_check("R3 newest", 1'b1, 32'hE4);
        pop_check("R3 second", 1'b1, 32'hE3);
        pop_check("R3 third", 1'b1, 32'hE2);
        pop_check("R3 oldest kept", 1'b1, 32'hE1);
        pop_check("R3 oldest overwritten, empty", 1'b0, 32'hE4);
        pop_check("R4 empty pop repeats", 1'b0, 32'hE4);
        push(32'hF0);
        pop_check("R4 index held on empty pop", 1'b1, 32'hF0);

        // checkpoint and recovery
        do_reset();
        pop_check("R1 empty after second reset", 1'b0, 32'h0);
        push(32'h10);
        drive(1'b1, 1'b0, 32'h20, 1'b1, 3'd3, 1'b0, '0);   // R6 checkpoint after own push
        pop_check("R2 wrong-path pop", 1'b1, 32'h20);
        push(32'h99);                                      // overwrites slot of 0x20
        push(32'h77);
        drive(1'b1, 1'b1, 32'hAA, 1'b1, 3'd5, 1'b1, 3'd3);  // R8 flush beats call/return/ckpt
        check("R8 no prediction during flush", {31'b0, pred_valid_o}, 32'h0);
        pop_check("R9 overwritten slot survives recovery", 1'b1, 32'h99);
        pop_check("R7 restored depth second entry", 1'b1, 32'h10);
        pop_check("R7 restored occupancy exhausted", 1'b0, 32'h0);
        push(32'h55);
        drive(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 3'd5);
        pop_check("R8 checkpoint dropped during flush", 1'b0, 32'h0);
        drive(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 3'd3);
        pop_check("R6 saved position persists", 1'b1, 32'h99);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule